// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block rescales one image line of unsigned samples from a source width to a destination width. Samples enter through a valid/ready stream and leave through a second valid/ready stream. A pulse on `line_go` starts a line and captures the line configuration: source width, destination width, a horizontal subsampling shift for chroma lines, and an initial phase. The block then derives the 16.16 step on its own with a serial divider, so software never programs the ratio.

For every output pixel, a 16.16 accumulator gives the source position. Its integer part selects the centre of an eight-tap window. Five bits of its fraction pick one of 32 coefficient phases. The eight weighted samples are summed, rounded, and clamped to the sample range. Samples that the window would need from outside the line are replaced by the first or last sample of the line. When upscaling, the same window serves several outputs, and during that time the input side is held off.

Coefficients are written into a staging table through a word write port, and only while an access enable is held high. A commit pulse marks the staged table for use. The table that filters a line is the one committed before that line's `line_go`, so the table can be reloaded while a line is running.

Top module: `hscale_poly`

## Requirements
- R1: After reset, `in_ready` and `out_valid` stay low until a line is started with `line_go`.
- R2: At `line_go` the block computes step = floor((W << 16) / dst_width), where W is the effective source width. The accumulator starts at `init_phase` (bits 15:0 are the fraction, the upper bits the integer position), and it advances by step after each accepted output.
- R3: The effective source width is W = ceil(src_width / 2^hsub_log2). Exactly W input samples are consumed per line, and the destination width applies unchanged.
- R4: The coefficient table has 64 32-bit words. Word 2p holds taps 0..3 of phase p and word 2p+1 holds taps 4..7, with tap 4m+b in byte b (bits 8b+7:8b), each a signed 8-bit value. Tap k weights the source sample at position n+k-3.
- R5: The phase is accumulator bits 15:11, and the integer part n = accumulator >> 16 is the centre position.
- R6: A tap position below 0 uses sample 0, and a tap position above W-1 uses sample W-1.
- R7: The output is (sum + 32) >> 6 using arithmetic shift, clamped to the range 0..255.
- R8: A coefficient write while `coef_access` is low has no effect.
- R9: A `coef_commit` pulse makes the staged table active at the next `line_go`. A line that is already running keeps the table it started with.
- R10: After reset, both tables hold a pass-through filter: in every phase tap 3 is 64 and all other taps are 0.
- R11: `in_ready` and `out_valid` are never high together, and each line delivers exactly `dst_width` outputs.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R13: After the last output, the block consumes any remaining source samples and then returns to idle with both handshakes low. Configuration inputs are ignored after `line_go` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_go | input | 1 | Starts a line and captures the configuration (taken only when idle) |
| src_width | input | 12 | Source line width before subsampling, 1 or more |
| dst_width | input | 12 | Destination line width, 1 or more |
| hsub_log2 | input | 2 | Log2 of the horizontal subsampling factor |
| init_phase | input | 20 | Initial accumulator value, 16 fraction bits |
| coef_access | input | 1 | Enables coefficient writes |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient word index |
| coef_wdata | input | 32 | Coefficient word, four signed taps |
| coef_commit | input | 1 | Marks the staged table for use at the next line |
| in_valid | input | 1 | Source sample valid |
| in_ready | output | 1 | Source sample accepted |
| in_data | input | 8 | Source sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted |
| out_data | output | 8 | Output pixel |

## Verification
The hardest situation to reach from the ports is a commit that lands while a line is in flight, where the old table must stay in force until the following line. The bench stages a complete new table and pulses commit only after the first output of a running line has been taken. It then checks that line against the old table and the next line against the new one. Right-edge replication is reached with a large initial integer phase, and the clamps are reached with an overshooting table applied to samples that alternate between 0 and 255. Random stalls on both handshakes also expose the output-hold and stall rules.

// File: rtl/hscale_poly.sv
module hscale_poly #(
  parameter int DW      = 8,
  parameter int WW      = 12,
  parameter int PH_BITS = 5,
  parameter int NTAP    = 8,
  parameter int FRAC    = 6,
  localparam int WPP    = NTAP / 4,
  localparam int NWORD  = (1 << PH_BITS) * WPP,
  localparam int AW     = $clog2(NWORD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_go,
  input  logic [WW-1:0] src_width,
  input  logic [WW-1:0] dst_width,
  input  logic [1:0]    hsub_log2,
  input  logic [19:0]   init_phase,
  input  logic          coef_access,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [31:0]   coef_wdata,
  input  logic          coef_commit,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int CENTRE = NTAP / 2 - 1;
  localparam int AHEAD  = NTAP - CENTRE;
  localparam int ACC_W  = WW + 20;
  localparam int NW     = ACC_W - 16;
  localparam int NB     = WW + 16;
  localparam int CNT_W  = $clog2(NB);
  localparam int DIX    = $clog2(NTAP);
  localparam int PW     = DW + 9;
  localparam int SW     = PW + DIX;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_RUN} state_t;

  state_t                      state_q;
  logic [WW-1:0]               w_q, ow_q, rcv_q, ocnt_q, rem_q;
  logic [NB-1:0]               num_q, step_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [ACC_W-1:0]            acc_q;
  logic [NTAP-1:0][DW-1:0]     win_q;
  logic [NWORD-1:0][31:0]      stage_q, act_q, unity_tbl;
  logic                        pend_q;

  logic [WW-1:0]               eff_w;
  logic [WW:0]                 rem_sh;
  logic                        ge;
  logic [NW-1:0]               nint, last_x;
  logic [PH_BITS-1:0]          ph;
  logic [NW:0]                 ahead_pos, need;
  logic                        more_out, running;
  logic signed [PW-1:0]        prod [NTAP];
  logic signed [SW-1:0]        sum, biased, shr;

  always_comb begin
    unity_tbl = '0;
    for (int p = 0; p < (1 << PH_BITS); p++)
      unity_tbl[p * WPP + CENTRE / 4][8 * (CENTRE % 4) +: 8] = 8'(1 << FRAC);
  end

  assign eff_w = WW'(({1'b0, src_width} + ((WW + 1)'(1) << hsub_log2) - (WW + 1)'(1)) >> hsub_log2);

  assign rem_sh = {rem_q, num_q[NB-1]};
  assign ge     = rem_sh >= {1'b0, ow_q};

  assign nint      = acc_q[ACC_W-1:16];
  assign ph        = acc_q[15 -: PH_BITS];
  assign last_x    = NW'(w_q) - NW'(1);
  assign ahead_pos = {1'b0, nint} + (NW + 1)'(AHEAD);
  assign need      = (ahead_pos < (NW + 1)'(w_q)) ? ahead_pos : (NW + 1)'(w_q);
  assign more_out  = ocnt_q != ow_q;
  assign running   = state_q == S_RUN;

  assign in_ready  = running && (more_out ? ((NW + 1)'(rcv_q) < need) : (rcv_q != w_q));
  assign out_valid = running && more_out && ((NW + 1)'(rcv_q) >= need);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic signed [NW+1:0] pos;
    logic [WW-1:0]        j;
    logic [DIX-1:0]       d;
    logic [AW-1:0]        widx;
    logic signed [7:0]    c;
    assign pos  = $signed({2'b00, nint}) + $signed((NW + 2)'(k - CENTRE));
    assign j    = (pos < 0) ? '0 :
                  (pos > $signed({2'b00, last_x})) ? last_x[WW-1:0] : pos[WW-1:0];
    assign d    = DIX'(rcv_q - WW'(1) - j);
    assign widx = AW'(ph * WPP + k / 4);
    assign c    = act_q[widx][8 * (k % 4) +: 8];
    assign prod[k] = c * $signed({1'b0, win_q[d]});
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAP; k++) sum = sum + SW'(prod[k]);
  end

  assign biased   = sum + HALF;
  assign shr      = biased >>> FRAC;
  assign out_data = (shr < 0) ? '0 : (shr > MAXV) ? MAXV[DW-1:0] : shr[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      stage_q <= unity_tbl;
    else if (coef_we && coef_access)
      stage_q[coef_addr] <= coef_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      w_q     <= '0;
      ow_q    <= '0;
      rcv_q   <= '0;
      ocnt_q  <= '0;
      rem_q   <= '0;
      num_q   <= '0;
      step_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      win_q   <= '0;
      act_q   <= unity_tbl;
      pend_q  <= 1'b0;
    end else begin
      if (coef_commit) pend_q <= 1'b1;
      case (state_q)
        S_IDLE: if (line_go) begin
          w_q    <= eff_w;
          ow_q   <= dst_width;
          acc_q  <= ACC_W'(init_phase);
          num_q  <= {eff_w, 16'b0};
          rem_q  <= '0;
          step_q <= '0;
          cnt_q  <= '0;
          rcv_q  <= '0;
          ocnt_q <= '0;
          state_q <= S_DIV;
          if (pend_q || coef_commit) begin
            act_q  <= stage_q;
            pend_q <= 1'b0;
          end
        end
        S_DIV: begin
          rem_q  <= WW'(ge ? rem_sh - {1'b0, ow_q} : rem_sh);
          step_q <= {step_q[NB-2:0], ge};
          num_q  <= num_q << 1;
          cnt_q  <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NB - 1)) state_q <= S_RUN;
        end
        S_RUN: begin
          if (in_valid && in_ready) begin
            win_q <= {win_q[NTAP-2:0], in_data};
            rcv_q <= rcv_q + WW'(1);
          end
          if (out_valid && out_ready) begin
            acc_q  <= acc_q + ACC_W'(step_q);
            ocnt_q <= ocnt_q + WW'(1);
          end
          if (!more_out && rcv_q == w_q) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt_q <= ow_q) && (rcv_q <= w_q));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  coef_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(coef_we && coef_access) |=> $stable(stage_q));

  // R9
  table_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(act_q));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_RUN) |-> (!in_ready && !out_valid));
endmodule

// File: tb/sim_hscale_poly.sv
module sim_hscale_poly;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_go = 1'b0;
  logic [11:0] src_width = '0, dst_width = '0;
  logic [1:0]  hsub_log2 = '0;
  logic [19:0] init_phase = '0;
  logic        coef_access = 1'b0, coef_we = 1'b0, coef_commit = 1'b0;
  logic [5:0]  coef_addr = '0;
  logic [31:0] coef_wdata = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;

  always #10 clk = ~clk;

  hscale_poly u0 (
    .clk(clk), .rst_n(rst_n), .line_go(line_go),
    .src_width(src_width), .dst_width(dst_width), .hsub_log2(hsub_log2),
    .init_phase(init_phase), .coef_access(coef_access), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .coef_commit(coef_commit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, fails = 0;
  int smp [256];
  logic [31:0] mdl_stage [64];
  logic [31:0] mdl_act [64];
  bit   mdl_pend = 0;
  int   expq [$];
  int   got;
  int   overlap;

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int taps_of(int kind, int p, int k);
    int q = p / 8;
    case (kind)
      1: case (k)
           0, 7: return 1;
           1, 6: return -1;
           2, 5: return -q;
           3:    return 64 - 2 * p + q;
           default: return 2 * p + q;
         endcase
      2: case (k)
           3:    return 96;
           2, 4: return -16;
           default: return 0;
         endcase
      default: return (k == 3) ? 64 : 0;
    endcase
  endfunction

  function automatic logic [31:0] tbl_word(int kind, int w);
    logic [31:0] r = '0;
    if (kind == 3) return 32'hA5C3_0000 ^ w;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(taps_of(kind, w / 2, (w % 2) * 4 + b));
    return r;
  endfunction

  function automatic int tap(int ph, int k);
    logic signed [7:0] c = mdl_act[ph * 2 + k / 4][8 * (k % 4) +: 8];
    return int'(c);
  endfunction

  task automatic wr(int addr, logic [31:0] d, bit acc);
    @(negedge clk);
    coef_we = 1'b1; coef_access = acc; coef_addr = 6'(addr); coef_wdata = d;
    if (acc) mdl_stage[addr] = d;
  endtask

  task automatic load_table(int kind, bit acc);
    for (int w = 0; w < 64; w++) wr(w, tbl_word(kind, w), acc);
    @(negedge clk);
    coef_we = 1'b0; coef_access = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    coef_commit = 1'b1; mdl_pend = 1;
    @(negedge clk);
    coef_commit = 1'b0;
  endtask

  task automatic run_line(string tag, int src, int dst, int hsub, int init,
                          int pat, bit rin, bit rout, bit mid);
    int w = (src + (1 << hsub) - 1) >> hsub;
    longint step, acc;
    for (int i = 0; i < w; i++)
      smp[i] = (pat == 0) ? int'($urandom % 256) :
               (pat == 1) ? (((i / 2) % 2 == 1) ? 255 : 0) : ((i * 37 + 11) % 256);
    @(negedge clk);
    if (mdl_pend) begin
      for (int i = 0; i < 64; i++) mdl_act[i] = mdl_stage[i];
      mdl_pend = 0;
    end
    expq.delete();
    step = (longint'(w) << 16) / dst;
    acc  = init;
    for (int o = 0; o < dst; o++) begin
      longint n = acc >> 16;
      int ph = int'((acc >> 11) & 31);
      int s = 0, r;
      for (int k = 0; k < 8; k++) begin
        longint p = n + k - 3;
        if (p < 0) p = 0;
        if (p > w - 1) p = w - 1;
        s += tap(ph, k) * smp[int'(p)];
      end
      r = (s + 32) >>> 6;
      expq.push_back(r < 0 ? 0 : (r > 255 ? 255 : r));
      acc += step;
    end
    line_go = 1'b1; src_width = 12'(src); dst_width = 12'(dst);
    hsub_log2 = 2'(hsub); init_phase = 20'(init);
    @(negedge clk);
    line_go = 1'b0;
    src_width = '1; dst_width = 12'd3; hsub_log2 = 2'd3; init_phase = 20'hFFFFF;
    got = 0; overlap = 0;
    fork
      begin
        int i = 0;
        while (i < w) begin
          @(negedge clk);
          in_valid = rin ? ($urandom % 4 != 0) : 1'b1;
          in_data  = 8'(smp[i]);
          #1;
          if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        bit hold = 0;
        int hold_d = 0;
        while (got < dst) begin
          @(negedge clk);
          if (hold) begin
            chk("R12 valid held", int'(out_valid), 1);
            chk("R12 data held", int'(out_data), hold_d);
          end
          out_ready = rout ? ($urandom % 3 != 0) : 1'b1;
          #1;
          if (in_ready && out_valid) overlap++;
          if (out_valid && out_ready) begin
            chk(tag, int'(out_data), expq[got]);
            got++;
            hold = 0;
          end else begin
            hold = out_valid;
            hold_d = int'(out_data);
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
      begin
        if (mid) begin
          wait (got >= 1);
          load_table(2, 1'b1);
          commit();
        end
      end
    join
    repeat (3) @(negedge clk);
    chk("R11 output count", got, dst);
    chk("R11 no overlap of handshakes", overlap, 0);
    chk("R13 idle in_ready", int'(in_ready), 0);
    chk("R13 idle out_valid", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mdl_stage[i] = tbl_word(0, i);
      mdl_act[i]   = tbl_word(0, i);
    end
    repeat (4) @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 0);
    chk("R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle in_ready", int'(in_ready), 0);
    chk("R1 idle out_valid", int'(out_valid), 0);

    run_line("R10 pass-through", 24, 24, 0, 0, 0, 0, 0, 0);

    load_table(1, 1'b1);
    commit();
    run_line("R2 R4 R5 downscale", 40, 17, 0, 'h400, 0, 1, 1, 0);
    run_line("R11 upscale stall", 9, 31, 0, 0, 2, 1, 1, 0);
    run_line("R3 chroma width", 45, 20, 2, 0, 0, 1, 0, 0);
    run_line("R6 edge replication", 30, 12, 0, 'hFC000, 2, 0, 1, 0);

    load_table(3, 1'b0);
    commit();
    run_line("R8 write without access", 40, 17, 0, 'h400, 0, 1, 1, 0);

    run_line("R9 old table mid commit", 60, 50, 0, 0, 1, 1, 1, 1);
    run_line("R7 round and clamp", 32, 45, 0, 'h800, 1, 1, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule